// File: doc/BRIEF.md
# Flash Erase Status Bit Generator

This block produces the byte returned on a read cycle while a flash device runs an embedded program or erase operation. It keeps three pieces of state: which sectors were selected for the erase under way, whether the operation is running, suspended or idle, and whether it has failed on a timeout. A read that falls on the status path returns a byte carrying two toggle bits and one timeout bit. Any other read returns the array data presented at the block's input.

The two toggle bits carry different information. Bit 6 flips on every status read while an operation is running and holds still while an erase is suspended. It therefore gives the mode but no sector information. Bit 2 flips only on reads whose sector was selected for erase. It flips the same way whether that erase is running or suspended. Reading both bits lets software tell which sectors are erasing and whether the erase is suspended.

Operation start, completion, suspend, resume, timeout and the reset command each arrive as single-cycle pulses from a command decoder outside this block. A program may be nested inside an erase suspend. A failure in that nested program returns to the suspended state, not to idle.

Top module: `flash_erase_status`

## Requirements
- R1: While reset is asserted, and on the first cycle after the two-stage synchronised release, `rd_valid` is 0, `rd_data` is 0 and the mode is idle.
- R2: A read happens in a cycle where `rd_oe` or `rd_ce` is high. Both high in the same cycle count as one read. `rd_valid` is high in the following cycle only, with `rd_data` registered at that edge. Between reads, `rd_data` holds its value.
- R3: In idle, a read returns `array_data` as it was in the read cycle.
- R4: Bit 6 of a status read shows the current toggle value. The value then inverts on every status read during an active erase, an active program or a program nested in a suspend. This continues after a failure.
- R5: While an erase is suspended with no nested program, bit 6 holds its value across reads.
- R6: Bit 2 shows its current value and then inverts on each read whose sector bit is set in the erase mask. This applies in active erase, in erase suspend and during a nested program.
- R7: Bit 2 holds on reads of sectors not in the mask. In erase suspend with no nested program, those reads return `array_data` and not status.
- R8: A `timeout` during an active operation sets the failed flag, which reads as bit 5. The flag stays set until `reset_cmd`. While it is set, `op_done` is ignored. A `timeout` in idle or in plain suspend has no effect.
- R9: `reset_cmd` with the failed flag set clears the flag. After a failure in a nested program, the mode returns to erase suspend with the mask kept. Otherwise it returns to idle and the mask is cleared. Without a failure, `reset_cmd` does nothing.
- R10: A command affects reads from the next cycle onward, and a read in the same cycle sees the previous state. Starting an operation from idle clears both toggle bits to 0.
- R11: A status byte has bit 6 = run toggle, bit 5 = failed and bit 2 = sector toggle. All other bits are 0.
- R12: Only one command is taken per cycle, in this priority: reset_cmd, timeout, op_done, suspend, resume, op_start. `suspend` acts only in active erase and `resume` only in erase suspend. `op_start` acts in idle, where `op_erase` chooses erase (mask loaded) or program. It also acts in erase suspend, but only for a program, which then nests. In all other cases it is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_oe | input | 1 | Read strobe, output-enable path |
| rd_ce | input | 1 | Read strobe, chip-enable path |
| rd_sector | input | SEC_W | Sector index of the read address |
| array_data | input | 8 | Array data for non-status reads |
| op_start | input | 1 | Start an embedded operation |
| op_erase | input | 1 | 1 = erase, 0 = program, with op_start |
| op_mask | input | NUM_SECTORS | Sectors selected for erase, with op_start |
| op_suspend | input | 1 | Suspend request |
| op_resume | input | 1 | Resume request |
| op_done | input | 1 | Embedded operation finished |
| timeout | input | 1 | Pulse-count limit exceeded |
| reset_cmd | input | 1 | Reset command from the decoder |
| rd_valid | output | 1 | Read result valid |
| rd_data | output | 8 | Read result byte |

## Verification
The bench targets suspend reads. Bit 6 must freeze there while bit 2 keeps toggling on selected sectors, and reads of other sectors must return array data. A design that toggles bit 6 in suspend would look busy to software. A design that returns status for unselected sectors would hide valid data. The bench also raises a timeout inside a nested program and then issues the reset command. A wrong design would drop to idle and lose the suspended erase with its mask, or would leave bit 5 set. The remaining targets are reads issued in the same cycle as a command, reads with both strobes high, and commands given in the wrong mode. A flawed design would show the new state one read too early, double-toggle, or change mode when it should not.

// File: rtl/fes_pkg.sv
package fes_pkg;
  typedef enum logic [2:0] {
    MD_IDLE  = 3'd0,
    MD_ERASE = 3'd1,
    MD_ESUSP = 3'd2,
    MD_PROG  = 3'd3,
    MD_SPROG = 3'd4
  } fes_mode_e;

  localparam int unsigned STAT_RUN_BIT  = 6;
  localparam int unsigned STAT_FAIL_BIT = 5;
  localparam int unsigned STAT_SEC_BIT  = 2;

  function automatic logic mode_running(input fes_mode_e m);
    return (m == MD_ERASE) || (m == MD_PROG) || (m == MD_SPROG);
  endfunction

  function automatic logic mode_has_mask(input fes_mode_e m);
    return (m == MD_ERASE) || (m == MD_ESUSP) || (m == MD_SPROG);
  endfunction
endpackage

// File: rtl/fes_mode_fsm.sv
module fes_mode_fsm
  import fes_pkg::*;
#(
  parameter int unsigned NUM_SECTORS = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   op_start,
  input  logic                   op_erase,
  input  logic [NUM_SECTORS-1:0] op_mask,
  input  logic                   op_suspend,
  input  logic                   op_resume,
  input  logic                   op_done,
  input  logic                   timeout,
  input  logic                   reset_cmd,
  output fes_mode_e              mode,
  output logic                   failed,
  output logic [NUM_SECTORS-1:0] mask,
  output logic                   launch
);
  fes_mode_e              mode_q, mode_d;
  logic                   fail_q, fail_d;
  logic [NUM_SECTORS-1:0] mask_q, mask_d;
  logic                   launch_d;
  logic                   run;

  assign run = mode_running(mode_q);

  always_comb begin
    mode_d   = mode_q;
    fail_d   = fail_q;
    mask_d   = mask_q;
    launch_d = 1'b0;
    if (reset_cmd && fail_q) begin
      fail_d = 1'b0;
      if (mode_q == MD_SPROG) begin
        mode_d = MD_ESUSP;
      end else begin
        mode_d = MD_IDLE;
        mask_d = '0;
      end
    end else if (timeout && run) begin
      fail_d = 1'b1;
    end else if (op_done && run && !fail_q) begin
      if (mode_q == MD_SPROG) begin
        mode_d = MD_ESUSP;
      end else begin
        mode_d = MD_IDLE;
        mask_d = '0;
      end
    end else if (op_suspend && mode_q == MD_ERASE) begin
      mode_d = MD_ESUSP;
    end else if (op_resume && mode_q == MD_ESUSP) begin
      mode_d = MD_ERASE;
    end else if (op_start) begin
      if (mode_q == MD_IDLE) begin
        launch_d = 1'b1;
        if (op_erase) begin
          mode_d = MD_ERASE;
          mask_d = op_mask;
        end else begin
          mode_d = MD_PROG;
        end
      end else if (mode_q == MD_ESUSP && !op_erase) begin
        mode_d = MD_SPROG;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MD_IDLE;
      fail_q <= 1'b0;
      mask_q <= '0;
    end else begin
      mode_q <= mode_d;
      fail_q <= fail_d;
      mask_q <= mask_d;
    end
  end

  assign mode   = mode_q;
  assign failed = fail_q;
  assign mask   = mask_q;
  assign launch = launch_d;

  // R8: failed flag only rises after a timeout
  a_r8_fail_needs_timeout: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fail_q) |-> $past(timeout));

  // R9: failed flag only clears after a reset command
  a_r9_fail_clear_by_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(fail_q) |-> $past(reset_cmd));

  // R12: suspend is only reachable from active erase or nested-program completion
  a_r12_suspend_entry: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MD_ESUSP && $past(mode_q) != MD_ESUSP) |->
      ($past(mode_q) == MD_ERASE || $past(mode_q) == MD_SPROG));
endmodule

// File: rtl/fes_toggle_gen.sv
module fes_toggle_gen
  import fes_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      rd_fire,
  input  fes_mode_e mode,
  input  logic      in_sel,
  input  logic      launch,
  output logic      tog_run,
  output logic      tog_sec
);
  logic run_q, run_d, sec_q, sec_d;
  logic flip_run, flip_sec;

  assign flip_run = rd_fire && mode_running(mode);
  assign flip_sec = rd_fire && in_sel && mode_has_mask(mode);

  always_comb begin
    run_d = run_q;
    sec_d = sec_q;
    if (launch) begin
      run_d = 1'b0;
      sec_d = 1'b0;
    end else begin
      if (flip_run) run_d = ~run_q;
      if (flip_sec) sec_d = ~sec_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      sec_q <= 1'b0;
    end else begin
      run_q <= run_d;
      sec_q <= sec_d;
    end
  end

  assign tog_run = run_q;
  assign tog_sec = sec_q;

  // R5: run toggle frozen on reads during plain erase suspend
  a_r5_run_hold_in_suspend: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_fire && mode == MD_ESUSP) |=> $stable(run_q));

  // R7: sector toggle holds on reads outside the selected sectors
  a_r7_sec_hold_outside: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_fire && !in_sel && !launch) |=> $stable(sec_q));

  // R10: a launch leaves both toggles at zero
  a_r10_launch_clears: assert property (@(posedge clk) disable iff (!rst_n)
    launch |=> (!run_q && !sec_q));
endmodule

// File: rtl/fes_read_path.sv
module fes_read_path
  import fes_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rd_fire,
  input  logic       use_status,
  input  logic       tog_run,
  input  logic       tog_sec,
  input  logic       failed,
  input  logic [7:0] array_data,
  output logic       rd_valid,
  output logic [7:0] rd_data
);
  logic [7:0] stat_byte, data_d, data_q;
  logic       valid_q;

  always_comb begin
    stat_byte                = '0;
    stat_byte[STAT_RUN_BIT]  = tog_run;
    stat_byte[STAT_FAIL_BIT] = failed;
    stat_byte[STAT_SEC_BIT]  = tog_sec;
    data_d = data_q;
    if (rd_fire) data_d = use_status ? stat_byte : array_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q  <= '0;
      valid_q <= 1'b0;
    end else begin
      data_q  <= data_d;
      valid_q <= rd_fire;
    end
  end

  assign rd_valid = valid_q;
  assign rd_data  = data_q;

  // R2: valid pulse follows a read by exactly one cycle
  a_r2_valid_after_read: assert property (@(posedge clk) disable iff (!rst_n)
    rd_fire |=> valid_q);
  a_r2_no_valid_without_read: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_fire |=> (!valid_q && $stable(data_q)));

  // R8: a status read reports the failed flag on bit 5
  a_r8_fail_bit_reported: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_fire && use_status) |=> (data_q[STAT_FAIL_BIT] == $past(failed)));
endmodule

// File: rtl/flash_erase_status.sv
module flash_erase_status
  import fes_pkg::*;
#(
  parameter int unsigned NUM_SECTORS = 8,
  localparam int unsigned SEC_W = (NUM_SECTORS > 1) ? $clog2(NUM_SECTORS) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   rd_oe,
  input  logic                   rd_ce,
  input  logic [SEC_W-1:0]       rd_sector,
  input  logic [7:0]             array_data,
  input  logic                   op_start,
  input  logic                   op_erase,
  input  logic [NUM_SECTORS-1:0] op_mask,
  input  logic                   op_suspend,
  input  logic                   op_resume,
  input  logic                   op_done,
  input  logic                   timeout,
  input  logic                   reset_cmd,
  output logic                   rd_valid,
  output logic [7:0]             rd_data
);
  logic [1:0]             rst_pipe;
  logic                   rst_s_n;
  fes_mode_e              mode;
  logic                   failed, launch, in_sel, rd_fire, use_status;
  logic [NUM_SECTORS-1:0] mask;
  logic                   tog_run, tog_sec;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_s_n = rst_pipe[1];

  assign rd_fire = rd_oe | rd_ce;

  always_comb begin
    in_sel = 1'b0;
    for (int i = 0; i < int'(NUM_SECTORS); i++) begin
      if (int'(rd_sector) == i) in_sel = mask[i];
    end
  end

  assign use_status = mode_running(mode) || failed || (mode == MD_ESUSP && in_sel);

  fes_mode_fsm #(.NUM_SECTORS(NUM_SECTORS)) u_fsm (
    .clk(clk), .rst_n(rst_s_n),
    .op_start(op_start), .op_erase(op_erase), .op_mask(op_mask),
    .op_suspend(op_suspend), .op_resume(op_resume), .op_done(op_done),
    .timeout(timeout), .reset_cmd(reset_cmd),
    .mode(mode), .failed(failed), .mask(mask), .launch(launch)
  );

  fes_toggle_gen u_tog (
    .clk(clk), .rst_n(rst_s_n), .rd_fire(rd_fire), .mode(mode),
    .in_sel(in_sel), .launch(launch), .tog_run(tog_run), .tog_sec(tog_sec)
  );

  fes_read_path u_rd (
    .clk(clk), .rst_n(rst_s_n), .rd_fire(rd_fire), .use_status(use_status),
    .tog_run(tog_run), .tog_sec(tog_sec), .failed(failed),
    .array_data(array_data), .rd_valid(rd_valid), .rd_data(rd_data)
  );

  // R11: status bytes never carry bits outside 6, 5 and 2
  a_r11_status_layout: assert property (@(posedge clk) disable iff (!rst_s_n)
    (rd_fire && use_status) |=> ((rd_data & 8'h9B) == 8'h00));
endmodule

// File: tb/tb_flash_erase_status.sv
`timescale 1ns/1ps
module tb_flash_erase_status;
  localparam int NS = 8;
  localparam int SW = 3;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          rd_oe, rd_ce, op_start, op_erase, op_suspend, op_resume;
  logic          op_done, timeout, reset_cmd;
  logic [SW-1:0] rd_sector;
  logic [7:0]    array_data;
  logic [NS-1:0] op_mask;
  logic          rd_valid;
  logic [7:0]    rd_data;

  int n_tests = 0;
  int n_fail  = 0;
  bit done_run = 0;

  // behavioural model: 0 idle, 1 erase, 2 suspend, 3 program, 4 nested program
  int      m_mode = 0;
  bit      m_fail = 0;
  bit [NS-1:0] m_mask = '0;
  bit      m_t6 = 0, m_t2 = 0;
  bit [7:0] m_data = 0;

  always #2.5 clk = ~clk;

  flash_erase_status #(.NUM_SECTORS(NS)) dut (
    .clk(clk), .rst_n(rst_n), .rd_oe(rd_oe), .rd_ce(rd_ce),
    .rd_sector(rd_sector), .array_data(array_data),
    .op_start(op_start), .op_erase(op_erase), .op_mask(op_mask),
    .op_suspend(op_suspend), .op_resume(op_resume), .op_done(op_done),
    .timeout(timeout), .reset_cmd(reset_cmd),
    .rd_valid(rd_valid), .rd_data(rd_data)
  );

  task automatic clear_in();
    rd_oe = 0; rd_ce = 0; rd_sector = '0; array_data = 8'h00;
    op_start = 0; op_erase = 0; op_mask = '0; op_suspend = 0;
    op_resume = 0; op_done = 0; timeout = 0; reset_cmd = 0;
  endtask

  task automatic chk(string tag, logic [8:0] act, logic [8:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got valid=%0b data=%02h, expected valid=%0b data=%02h",
               tag, act[8], act[7:0], exp[8], exp[7:0]);
    end
  endtask

  // Inputs are already driven (at a negedge). Predict, clock, compare.
  task automatic tick(string tag);
    bit rd, run, sel, st;
    bit exp_v;
    run = (m_mode == 1) || (m_mode == 3) || (m_mode == 4);
    rd  = rd_oe || rd_ce;
    sel = m_mask[rd_sector] && (m_mode == 1 || m_mode == 2 || m_mode == 4);
    st  = run || m_fail || (m_mode == 2 && sel);
    exp_v = rd;
    if (rd) m_data = st ? {1'b0, m_t6, m_fail, 2'b00, m_t2, 2'b00} : array_data;
    if (rd && run) m_t6 = !m_t6;
    if (rd && sel) m_t2 = !m_t2;
    if (reset_cmd && m_fail) begin
      m_fail = 0;
      if (m_mode == 4) m_mode = 2; else begin m_mode = 0; m_mask = '0; end
    end else if (timeout && run) m_fail = 1;
    else if (op_done && run && !m_fail) begin
      if (m_mode == 4) m_mode = 2; else begin m_mode = 0; m_mask = '0; end
    end else if (op_suspend && m_mode == 1) m_mode = 2;
    else if (op_resume && m_mode == 2) m_mode = 1;
    else if (op_start) begin
      if (m_mode == 0) begin
        m_t6 = 0; m_t2 = 0;
        if (op_erase) begin m_mode = 1; m_mask = op_mask; end
        else m_mode = 3;
      end else if (m_mode == 2 && !op_erase) m_mode = 4;
    end
    @(posedge clk);
    @(negedge clk);
    chk(tag, {rd_valid, rd_data}, {exp_v, m_data});
    clear_in();
  endtask

  task automatic rd(bit oe, bit ce, int sec, logic [7:0] d, string tag);
    rd_oe = oe; rd_ce = ce; rd_sector = SW'(sec); array_data = d;
    tick(tag);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done_run) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: got running, expected finished");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    clear_in();
    rst_n = 0;
    repeat (3) @(negedge clk);
    chk("R1 in reset", {rd_valid, rd_data}, 9'h000);
    rst_n = 1;
    @(negedge clk); @(negedge clk); @(negedge clk);
    chk("R1 after release", {rd_valid, rd_data}, 9'h000);

    // idle reads, each strobe
    rd(1, 0, 0, 8'hA5, "R3 idle oe");
    rd(0, 1, 3, 8'h3C, "R3 idle ce");
    tick("R2 idle no read holds data");
    rd(1, 1, 5, 8'h81, "R2 both strobes");

    // erase start with a read in the same cycle sees idle
    op_start = 1; op_erase = 1; op_mask = 8'b0010_0101;
    rd(1, 0, 0, 8'h77, "R10 read during start");
    rd(1, 0, 0, 8'h11, "R6 erase sel");
    rd(0, 1, 2, 8'h11, "R6 erase sel ce");
    rd(1, 0, 1, 8'h11, "R7 erase unsel");
    rd(1, 1, 5, 8'h11, "R2 both strobes status");
    rd(1, 0, 7, 8'h11, "R4 erase any");
    // ignored commands during erase
    op_resume = 1; tick("R12 resume in erase");
    op_start = 1; op_erase = 0; tick("R12 start in erase");
    rd(1, 0, 3, 8'h22, "R12 still erasing");
    reset_cmd = 1; tick("R9 reset without fail");
    rd(1, 0, 0, 8'h22, "R9 still erasing");

    // suspend
    op_suspend = 1; rd(1, 0, 2, 8'h33, "R10 read during suspend cmd");
    rd(1, 0, 0, 8'h44, "R5 susp sel");
    rd(1, 0, 2, 8'h45, "R5 susp sel");
    rd(0, 1, 5, 8'h46, "R6 susp sel");
    rd(1, 0, 4, 8'h9E, "R7 susp unsel array");
    timeout = 1; tick("R8 timeout in suspend ignored");
    rd(1, 0, 0, 8'h47, "R8 no fail in suspend");
    op_start = 1; op_erase = 1; tick("R12 erase start in suspend");
    rd(1, 0, 6, 8'h5A, "R12 still suspended");

    // nested program, fail, reset back to suspend
    op_start = 1; op_erase = 0; tick("R12 nested program");
    rd(1, 0, 6, 8'h00, "R4 nested any");
    rd(1, 0, 0, 8'h00, "R6 nested sel");
    timeout = 1; tick("R8 timeout nested");
    rd(1, 0, 1, 8'h00, "R8 fail bit");
    op_done = 1; tick("R8 done ignored while failed");
    rd(1, 0, 2, 8'h00, "R4 toggles while failed");
    reset_cmd = 1; tick("R9 reset nested fail");
    rd(1, 0, 4, 8'hC3, "R9 back in suspend unsel");
    rd(1, 0, 5, 8'hC3, "R9 back in suspend sel");

    // resume and finish
    op_resume = 1; tick("R12 resume");
    rd(1, 0, 2, 8'h00, "R4 resumed");
    op_done = 1; tick("R12 done");
    rd(1, 0, 2, 8'h6B, "R3 idle after done");
    op_resume = 1; rd(1, 0, 0, 8'h6C, "R12 resume in idle");
    op_suspend = 1; tick("R12 suspend in idle");
    rd(1, 0, 0, 8'h6D, "R3 still idle");

    // program from idle, suspend ignored, fail, reset to idle
    op_start = 1; op_erase = 0; op_mask = 8'hFF; tick("R10 program start");
    rd(1, 0, 0, 8'h00, "R10 toggles cleared");
    rd(0, 1, 1, 8'h00, "R7 program no sector toggle");
    op_suspend = 1; tick("R12 suspend in program");
    rd(1, 0, 0, 8'h00, "R4 program toggles");
    timeout = 1; rd(1, 0, 0, 8'h00, "R10 read during timeout");
    rd(1, 0, 0, 8'h00, "R8 program failed");
    reset_cmd = 1; tick("R9 reset program fail");
    rd(1, 0, 0, 8'hE7, "R9 idle after reset");

    // second erase: toggles restart from zero
    op_start = 1; op_erase = 1; op_mask = 8'b1000_0000; tick("R10 erase again");
    rd(1, 0, 7, 8'h00, "R10 cleared sel");
    rd(1, 0, 7, 8'h00, "R6 toggling");
    rd(1, 0, 6, 8'h00, "R11 layout");
    timeout = 1; tick("R8 timeout erase");
    op_done = 1; tick("R8 done ignored");
    reset_cmd = 1; tick("R9 reset erase fail");
    rd(1, 0, 7, 8'h12, "R9 idle mask cleared");
    repeat (3) tick("R2 quiet");

    done_run = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule